// File: doc/BRIEF.md
# Rotate and Mask Field Extractor

This block pulls an arbitrary contiguous bit field out of a 16-bit operand in a single pass. It first picks one operand from a set of sources. The sources are the top-of-stack value, the 4-bit stack pointer, a 16-bit literal, or any one of five 16-bit slices of an 80-bit microword. The operand is rotated right by 0 to 15 places. Then a programmable count of bits is cleared from the most significant end and another count from the least significant end.

By choosing the rotate amount so that the wanted field lands at the bottom, and setting the two clear counts to trim what lies around it, any field of any width at any position can be isolated. The result is registered once. The full 16-bit value drives the data result, and its low 11 bits drive the branch-address result.

There is no sequencing state. The only storage is the output register, which loads on every clock edge.

Top module: `rotmask_extract`

## Requirements
- R1: With `src_sel` = 0 the operand is `stack_data`.
- R2: With `src_sel` = 1 the operand is `stack_ptr` zero-extended to 16 bits.
- R3: With `src_sel` = 2 the operand is `literal`.
- R4: With `src_sel` = 3+k (k = 0..4) the operand is `uword[16k+15:16k]`.
- R5: The operand is rotated right by `rot_amt`: pre-mask bit i equals operand bit (i + `rot_amt`) mod 16.
- R6: The top `lmask` bits (positions 15 down to 16-`lmask`) of the result are zero.
- R7: The bottom `rmask` bits (positions `rmask`-1 down to 0) of the result are zero.
- R8: When `lmask` + `rmask` >= 16 the result is all zeros.
- R9: Rotation happens before masking, so the two clear counts apply to the rotated value.
- R10: `branch_out` always equals `data_out[10:0]`.
- R11: The outputs reflect the inputs present at the previous rising clock edge (one cycle of latency), and do not change between edges.
- R12: While `rst_n` is low both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Operand source select |
| stack_data | input | 16 | Top-of-stack value |
| stack_ptr | input | 4 | Stack pointer |
| literal | input | 16 | Literal operand |
| uword | input | 80 | Wide microword, five 16-bit slices |
| rot_amt | input | 4 | Right-rotate distance |
| lmask | input | 4 | Bits cleared from the most significant end |
| rmask | input | 4 | Bits cleared from the least significant end |
| data_out | output | 16 | Registered extracted value |
| branch_out | output | 11 | Low 11 bits of the extracted value |

## Verification
Some properties are checked by assertions on every cycle. These are the cleared regions at both ends, the agreement of the branch result with the data result, and that the result's population count equals the operand's when neither mask is active. These hold whatever the operand values are. Only the bench scenarios can show the exact bit placement for each source selection, the rotate direction, the order of rotate and mask, and the all-zero result from overlapping masks, because those need known operand values and expected words.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
    localparam int DW    = 16;
    localparam int CW    = $clog2(DW);
    localparam int NSL   = 5;
    localparam int UW    = DW * NSL;
    localparam int SPW   = 4;
    localparam int BRW   = 11;
    localparam int SELW  = 3;

    typedef enum logic [SELW-1:0] {
        SRC_STACK  = 3'd0,
        SRC_SPTR   = 3'd1,
        SRC_LIT    = 3'd2,
        SRC_SLICE0 = 3'd3,
        SRC_SLICE1 = 3'd4,
        SRC_SLICE2 = 3'd5,
        SRC_SLICE3 = 3'd6,
        SRC_SLICE4 = 3'd7
    } src_sel_e;
endpackage

// File: rtl/rotmask_src_mux.sv
module rotmask_src_mux
    import rotmask_pkg::*;
#(
    parameter int W   = DW,
    parameter int NS  = NSL,
    parameter int SPB = SPW
) (
    input  src_sel_e            sel,
    input  logic [W-1:0]        stack_data,
    input  logic [SPB-1:0]      stack_ptr,
    input  logic [W-1:0]        literal,
    input  logic [W*NS-1:0]     uword,
    output logic [W-1:0]        operand
);
    logic [W-1:0] slice [NS];

    for (genvar k = 0; k < NS; k++) begin : g_slice
        assign slice[k] = uword[k*W +: W];
    end

    always_comb begin
        unique case (sel)
            SRC_STACK:  operand = stack_data;
            SRC_SPTR:   operand = W'(stack_ptr);
            SRC_LIT:    operand = literal;
            SRC_SLICE0: operand = slice[0];
            SRC_SLICE1: operand = slice[1];
            SRC_SLICE2: operand = slice[2];
            SRC_SLICE3: operand = slice[3];
            SRC_SLICE4: operand = slice[4];
            default:    operand = '0;
        endcase
    end
endmodule

// File: rtl/rotmask_rotator.sv
module rotmask_rotator
    import rotmask_pkg::*;
#(
    parameter int W = DW,
    localparam int C = $clog2(W)
) (
    input  logic [W-1:0] din,
    input  logic [C-1:0] amt,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [C+1];

    assign stage[0] = din;

    for (genvar s = 0; s < C; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][D-1:0], stage[s][W-1:D]} : stage[s];
    end

    assign dout = stage[C];
endmodule

// File: rtl/rotmask_masker.sv
module rotmask_masker
    import rotmask_pkg::*;
#(
    parameter int W = DW,
    localparam int C = $clog2(W)
) (
    input  logic [W-1:0] din,
    input  logic [C-1:0] lcut,
    input  logic [C-1:0] rcut,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic keep;
        assign keep    = (int'(rcut) <= i) && ((i + int'(lcut)) < W);
        assign dout[i] = din[i] & keep;
    end
endmodule

// File: rtl/rotmask_extract.sv
module rotmask_extract
    import rotmask_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SELW-1:0]  src_sel,
    input  logic [DW-1:0]    stack_data,
    input  logic [SPW-1:0]   stack_ptr,
    input  logic [DW-1:0]    literal,
    input  logic [UW-1:0]    uword,
    input  logic [CW-1:0]    rot_amt,
    input  logic [CW-1:0]    lmask,
    input  logic [CW-1:0]    rmask,
    output logic [DW-1:0]    data_out,
    output logic [BRW-1:0]   branch_out
);
    logic [DW-1:0] operand;
    logic [DW-1:0] rotated;
    logic [DW-1:0] masked;

    rotmask_src_mux #(.W(DW), .NS(NSL), .SPB(SPW)) u_mux (
        .sel        (src_sel_e'(src_sel)),
        .stack_data (stack_data),
        .stack_ptr  (stack_ptr),
        .literal    (literal),
        .uword      (uword),
        .operand    (operand)
    );

    rotmask_rotator #(.W(DW)) u_rot (
        .din  (operand),
        .amt  (rot_amt),
        .dout (rotated)
    );

    rotmask_masker #(.W(DW)) u_msk (
        .din  (rotated),
        .lcut (lmask),
        .rcut (rmask),
        .dout (masked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out   <= '0;
            branch_out <= '0;
        end else begin
            data_out   <= masked;
            branch_out <= masked[BRW-1:0];
        end
    end

    // R6
    top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lmask) != 0) |->
        ((32'(data_out) >> (DW - int'($past(lmask)))) == 0));

    // R7
    bottom_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rmask) != 0) |->
        ((32'(data_out) & ((32'd1 << $past(rmask)) - 32'd1)) == 0));

    // R10
    branch_match_chk: assert property (@(posedge clk)
        branch_out == data_out[BRW-1:0]);

    // R5
    rot_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lmask) == 0 && $past(rmask) == 0) |->
        ($countones(data_out) == $countones($past(operand))));
endmodule

// File: tb/rotmask_extract_tb.sv
module rotmask_extract_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_sel = '0;
    logic [15:0] stack_data = 16'hA5C3;
    logic [3:0]  stack_ptr = 4'h9;
    logic [15:0] literal = 16'h1234;
    logic [79:0] uword = {16'hCAFE, 16'hBEEF, 16'hF00F, 16'h8000, 16'h0001};
    logic [3:0]  rot_amt = '0;
    logic [3:0]  lmask = '0;
    logic [3:0]  rmask = '0;
    logic [15:0] data_out;
    logic [10:0] branch_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rotmask_extract dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .stack_data(stack_data),
        .stack_ptr(stack_ptr), .literal(literal), .uword(uword),
        .rot_amt(rot_amt), .lmask(lmask), .rmask(rmask),
        .data_out(data_out), .branch_out(branch_out)
    );

    // {sel, rot, lmask, rmask, expected}
    localparam int NV = 16;
    localparam logic [30:0] VEC [NV] = '{
        {3'd0, 4'd0,  4'd0,  4'd0,  16'hA5C3},  // R1
        {3'd1, 4'd0,  4'd0,  4'd0,  16'h0009},  // R2
        {3'd2, 4'd4,  4'd0,  4'd0,  16'h4123},  // R3 R5
        {3'd3, 4'd1,  4'd0,  4'd0,  16'h8000},  // R4 R5
        {3'd4, 4'd15, 4'd0,  4'd0,  16'h0001},  // R4 R5
        {3'd7, 4'd8,  4'd0,  4'd0,  16'hFECA},  // R4
        {3'd6, 4'd0,  4'd4,  4'd0,  16'h0EEF},  // R6
        {3'd6, 4'd0,  4'd0,  4'd4,  16'hBEE0},  // R7
        {3'd5, 4'd4,  4'd0,  4'd0,  16'hFF00},  // R4 R5
        {3'd5, 4'd4,  4'd4,  4'd4,  16'h0F00},  // R9
        {3'd2, 4'd8,  4'd8,  4'd0,  16'h0012},  // R9
        {3'd0, 4'd0,  4'd8,  4'd8,  16'h0000},  // R8
        {3'd0, 4'd0,  4'd15, 4'd0,  16'h0001},  // R6
        {3'd0, 4'd0,  4'd0,  4'd15, 16'h8000},  // R7
        {3'd2, 4'd8,  4'd12, 4'd0,  16'h0002},  // R9
        {3'd0, 4'd0,  4'd9,  4'd9,  16'h0000}   // R8
    };

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [30:0] v);
        src_sel = v[30:28];
        rot_amt = v[27:24];
        lmask   = v[23:20];
        rmask   = v[19:16];
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R12: reset holds outputs at zero
        drive(VEC[0]);
        repeat (3) @(negedge clk);
        check16("R12 data", data_out, 16'h0000);
        check16("R12 branch", {5'd0, branch_out}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(negedge clk);
            check16($sformatf("vec%0d data", i), data_out, VEC[i][15:0]);
            check16("R10 branch", {5'd0, branch_out}, {5'd0, VEC[i][10:0]});
        end

        // R11: no change before the edge, new value after one edge
        @(negedge clk);
        drive({3'd2, 4'd0, 4'd0, 4'd0, 16'h0});
        @(negedge clk);
        check16("R11 settle", data_out, 16'h1234);
        drive({3'd1, 4'd0, 4'd0, 4'd0, 16'h0});
        #2;
        check16("R11 hold", data_out, 16'h1234);
        @(negedge clk);
        check16("R11 update", data_out, 16'h0009);

        // R2: all-ones pointer still zero-extended
        stack_ptr = 4'hF;
        @(negedge clk);
        check16("R2 ext", data_out, 16'h000F);

        // R12: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check16("R12 mid", data_out, 16'h0000);
        check16("R12 midbr", {5'd0, branch_out}, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule